// File: doc/BRIEF.md
# Gated Synchronous Power-of-Two Clock Divider

The block turns one input clock into three divided clocks at one half, one quarter and one eighth of the input rate. Each divided output also comes with a complementary version. All outputs are bits of one shared 3-bit counter, so any edges that fall on the same input edge switch together with no relative offset.

A hold request freezes the divider without chopping the internal clock. The request is captured on the falling input edge, so the counter's clock-enable changes only while the input clock is low and no partial pulse can reach the counter. While frozen the counter keeps its value. On release it continues from that value, as if the freeze had never happened.

A master clear forces every divided output low at once, whatever the clock or the hold request is doing. Its release is synchronised to the input clock, so several instances released together restart in step on the same edge.

Top module: `pow2_clk_div`

## Requirements
- R1: `div_o[0]`, `div_o[1]` and `div_o[2]` are bits 0, 1 and 2 of a count of enabled rising clock edges. They divide the input clock by 2, 4 and 8.
- R2: `div_o[k]` (k = 1, 2) changes only on a rising edge where `div_o[k-1]` falls from 1 to 0 on that same edge.
- R3: `div_n_o` is always the bitwise inverse of `div_o`.
- R4: `hold_i` is sampled on each falling clock edge. While the sampled value is 1, the following rising edges leave `div_o` unchanged.
- R5: The freeze control changes only while the clock is low. A change of `hold_i` made after a falling edge has no effect on the next rising edge. It takes effect from the falling edge after that.
- R6: After a freeze ends, the count goes on from the held value. No step is skipped or repeated.
- R7: While `mclr_i` is 1, `div_o` is 0 and `div_n_o` is all ones, regardless of the clock and `hold_i`. This takes effect without waiting for a clock edge.
- R8: After `mclr_i` or `rst_ni` is released between edges, the first two rising edges leave the count at 0. The third rising edge advances it to 1.
- R9: While `rst_ni` is 0, `div_o` is 0, `div_n_o` is all ones and the hold capture is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Freeze request, sampled on the falling edge |
| mclr_i | input | 1 | Master clear, active high, asynchronous assert, synchronised release |
| div_o | output | 3 | Divided clocks: bit 0 is /2, bit 1 is /4, bit 2 is /8 |
| div_n_o | output | 3 | Complements of div_o |

## Verification
Every cycle, the assertions check four things: the edge alignment between neighbouring stages, the frozen value whenever the captured hold is set, the forced-low outputs during master clear, and the rule that the freeze control moves only while the clock is low. Some behaviour only the bench scenarios can show. That covers the exact count sequence against an independent count of enabled edges, and resumption after freezes of varied length. It also covers how late changes to the hold request are handled and the three-edge restart after a clear.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
  localparam int unsigned DIV_STAGES  = 3;
  localparam int unsigned SYNC_STAGES = 2;
  typedef logic [DIV_STAGES-1:0] div_vec_t;
endpackage

// File: rtl/clr_sync.sv
module clr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic run_o
);
  logic [STAGES-1:0] sh_q;

  // assert asynchronously, release on rising edges only
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign run_o = sh_q[STAGES-1];
endmodule

// File: rtl/hold_capture.sv
module hold_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= hold_i;
  end

  assign hold_o = hold_q;

  // p_gate_low_r5: gate moves only while clock is low
  always @(hold_q) begin
    if (rst_ni) p_gate_low_r5: assert (!clk_i);
  end
endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             run_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge run_i) begin
    if (!run_i)    cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div
  import pow2_div_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hold_i,
  input  logic                  mclr_i,
  output logic [DIV_STAGES-1:0] div_o,
  output logic [DIV_STAGES-1:0] div_n_o
);
  logic     arst_n, run, hold_q;
  div_vec_t cnt;

  assign arst_n = rst_ni & ~mclr_i;

  clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .arst_ni(arst_n),
    .run_o  (run)
  );

  hold_capture u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold_i),
    .hold_o(hold_q)
  );

  div_counter #(.WIDTH(DIV_STAGES)) u_cnt (
    .clk_i(clk_i),
    .run_i(run),
    .en_i (~hold_q),
    .cnt_o(cnt)
  );

  assign div_o   = cnt;
  assign div_n_o = ~cnt;

  logic past_ok;
  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // stage k toggles only where stage k-1 falls
  for (genvar k = 1; k < DIV_STAGES; k++) begin : g_align
    p_align_r2: assert property (@(posedge clk_i) disable iff (!arst_n)
      (past_ok && div_o[k] != $past(div_o[k])) |-> ($past(div_o[k-1]) && !div_o[k-1]));
  end

  p_freeze_r4: assert property (@(posedge clk_i) disable iff (!arst_n)
    (past_ok && $past(hold_q)) |-> $stable(div_o));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |-> (div_o == '0 && div_n_o == '1));
endmodule

// File: tb/pow2_clk_div_tb_top.sv
module pow2_clk_div_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni, hold_i, mclr_i;
  logic [2:0] div_o, div_n_o;

  int n_tests = 0, n_fail = 0;
  logic [2:0] ref_cnt = '0;
  logic       ref_hold = 1'b0;
  int         rel = 0;
  logic       in_clr = 1'b1;
  logic [7:0] lfsr = 8'h5a;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pow2_clk_div dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .mclr_i(mclr_i),
    .div_o(div_o), .div_n_o(div_n_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: advance reference, check, then set hold for the next fall
  task automatic cyc(input logic h, input string tag);
    @(posedge clk_i);
    if (in_clr) begin
      ref_cnt = '0; rel = 0;
    end else begin
      rel++;
      if (rel >= 3 && !ref_hold) ref_cnt = ref_cnt + 3'd1;
    end
    #1;
    chk(div_o == ref_cnt, tag, div_o, ref_cnt);
    chk(div_n_o == ~div_o, "R3 complement", div_n_o, ~div_o);
    #1;
    hold_i = h; ref_hold = h;
  endtask

  // hold change after the falling edge: must not affect the next rising edge (R5)
  task automatic late_hold(input logic h);
    @(posedge clk_i);
    if (!in_clr) begin
      rel++;
      if (rel >= 3 && !ref_hold) ref_cnt = ref_cnt + 3'd1;
    end
    #1 chk(div_o == ref_cnt, "R5 late pre", div_o, ref_cnt);
    #6 hold_i = h;
    @(posedge clk_i);
    rel++;
    if (!ref_hold) ref_cnt = ref_cnt + 3'd1;
    #1 chk(div_o == ref_cnt, "R5 late change ignored on next edge", div_o, ref_cnt);
    #1 ref_hold = h;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; mclr_i = 1'b0; hold_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 chk(div_o == 3'b000 && div_n_o == 3'b111, "R9 reset state", div_o, 3'b000);
    #1 rst_ni = 1'b1; in_clr = 1'b0; rel = 0;
    // R8: restart on third edge
    cyc(1'b0, "R8 reset release");
    cyc(1'b0, "R8 reset release");
    cyc(1'b0, "R8 third edge");
    // R1 R2: free run
    for (int i = 0; i < 40; i++) cyc(1'b0, "R1 R2 free run");
    // R4 R6: freeze blocks of varied length
    for (int b = 1; b < 7; b++) begin
      for (int i = 0; i < b; i++) cyc(1'b1, "R4 frozen");
      for (int i = 0; i < b + 2; i++) cyc(1'b0, "R6 resume");
    end
    // R4 R6: pseudo-random hold pattern
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc(lfsr[0], "R4 R6 random hold");
    end
    cyc(1'b0, "R6 resume");
    // R5: late hold changes
    late_hold(1'b1);
    cyc(1'b1, "R5 frozen after late set");
    cyc(1'b1, "R5 frozen");
    late_hold(1'b0);
    cyc(1'b0, "R5 running after late clear");
    for (int i = 0; i < 5; i++) cyc(1'b0, "R1 run");
    // R7: master clear mid-run, with hold toggling
    cyc(1'b1, "R1 pre clear");
    @(negedge clk_i) mclr_i = 1'b1;
    #1 chk(div_o == 3'b000, "R7 async clear", div_o, 3'b000);
    in_clr = 1'b1;
    for (int i = 0; i < 6; i++) cyc(i[0], "R7 held clear");
    for (int i = 0; i < 6; i++) cyc(1'b0, "R7 held clear");
    #1 mclr_i = 1'b0; in_clr = 1'b0; rel = 0;
    cyc(1'b0, "R8 clear release edge 1");
    cyc(1'b0, "R8 clear release edge 2");
    cyc(1'b0, "R8 clear release edge 3");
    for (int i = 0; i < 20; i++) cyc(1'b0, "R1 R2 after clear");
    // R9: reset mid-run
    @(negedge clk_i) rst_ni = 1'b0;
    #1 chk(div_o == 3'b000 && div_n_o == 3'b111, "R9 reset mid-run", div_o, 3'b000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule